// File: doc/BRIEF.md
# MMC Card Initialization Command Sequencer

This block is the host-side controller that brings a freshly powered MMC device from its idle state to a running multi-block read. It does not build serial frames. On each step it presents a command index and a 32-bit argument to an external command-frame serializer for one cycle. It then waits for whatever completes that step: a response-received strobe for commands with a normal response, a busy-released strobe for commands that hold the data line busy, or nothing at all for the reset command.

The sequence is fixed. The block first resets the device. It then polls the operating-condition command until the device reports power-up complete, reads the identification, and assigns the relative address given at start. Next it selects the card and, through two register-write commands, widens the bus to eight bits and enables high-speed timing. At that point it raises a flag that tells the clock generator to leave the slow identification rate. It then sets the block length and starts a streaming read. It counts the blocks that the data receiver reports and then issues stop and status commands.

Every wait is guarded by a cycle timeout. When the timeout expires, the block raises an error and drops back to idle.

Top module: `mmc_init_seq`

## Requirements
- R1: After reset, cmd_req_o, done_o, err_o and clk_fast_o are all low.
- R2: The commands issue in this order: index 0; index 1, repeated until a response arrives with rsp_ready_i = 1; then 2, 3, 7, 6, 6, 16, 18, 12, 13. No command issues before start_i is seen in idle.
- R3: A command request is a single-cycle pulse of cmd_req_o. The command after index 0 follows in the very next cycle, because index 0 waits for nothing. Every other command issues in the cycle after the strobe that completed the previous step.
- R4: Indexes 3, 7 and 13 carry the relative address latched from rca_i at start in bits [31:16], with zeros in bits [15:0]. Index 1 carries OCR_ARG, index 16 carries BLOCK_LEN, index 18 carries READ_ADDR, and indexes 0, 2 and 12 carry zero. Later changes on rca_i and blk_cnt_i have no effect on the run.
- R5: Each index-6 argument holds access mode 2'b11 in bits [25:24], register number in [23:16], value in [15:8] and command set 0 in [2:0], with every other bit zero. The first write sets register 183 to 0x02 (giving 0x03B70200). The second sets register 185 to 0x01 (giving 0x03B90100).
- R6: Steps 7, both 6 steps and 12 complete only on busy_clr_i. All other waiting steps complete only on rsp_valid_i. The strobe of the wrong kind is ignored.
- R7: After the index-18 response, the block waits for the number of blk_done_i pulses latched from blk_cnt_i at start, then issues index 12 in the cycle after the last pulse. With a count of zero, index 12 follows the index-18 response directly.
- R8: clk_fast_o rises in the cycle after busy_clr_i completes the register-185 write, so it is high for index 16 onward. It is cleared by start and by an error.
- R9: done_o rises in the cycle after the index-13 response and stays high until the next start.
- R10: A step whose strobe arrives within TIMEOUT cycles after its request cycle proceeds. If no strobe has arrived by then, err_o rises TIMEOUT+1 cycles after the request, the block returns to idle and issues nothing more, and a later strobe is ignored. The same limit applies between block pulses.
- R11: A start with rca_i equal to zero (the address that would deselect the card) raises err_o in the next cycle and issues no command.
- R12: start_i is ignored while a sequence is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a sequence (accepted in idle only) |
| rca_i | input | 16 | Relative address to assign, latched at start |
| blk_cnt_i | input | BLK_W | Number of blocks to stream, latched at start |
| rsp_valid_i | input | 1 | Response received for the current command |
| rsp_ready_i | input | 1 | Power-up status bit of the operating-condition response, valid with rsp_valid_i |
| busy_clr_i | input | 1 | Busy released after a busy-type command |
| blk_done_i | input | 1 | One data block received |
| cmd_req_o | output | 1 | One-cycle request to the frame serializer |
| cmd_idx_o | output | 6 | Command index, valid with cmd_req_o |
| cmd_arg_o | output | 32 | Command argument, valid with cmd_req_o |
| clk_fast_o | output | 1 | Select the fast bus clock |
| done_o | output | 1 | Sequence completed (sticky until start) |
| err_o | output | 1 | Timeout or invalid start (sticky until start) |

## Verification
Every result has a fixed latency. A request appears one cycle after start. It also appears one cycle after the strobe that completes the previous step, or one cycle after the last block pulse. done_o follows the status response by one cycle. err_o follows an unanswered request by exactly TIMEOUT+1 cycles.

The bench stamps each request and each strobe it drives with a cycle number, sampled at the falling edge. It compares every request's cycle against the stamp of the event that should have caused it, and it compares each index and argument against a list it builds from the requirements.

The bench sweeps the number of polls, the block count and the response delay. The delay patterns are 1 cycle, exactly TIMEOUT, and a mixed pattern in which the wrong-kind strobe is driven first as a decoy. It also hangs each step in turn and answers one cycle late.

// File: rtl/mmc_seq_pkg.sv
package mmc_seq_pkg;

  localparam int IDX_W = 6;
  localparam int ARG_W = 32;
  localparam int RCA_W = 16;

  // Sequence position; the order of the values is the issue order.
  typedef enum logic [3:0] {
    ST_GO_IDLE,
    ST_OP_COND,
    ST_ALL_CID,
    ST_SET_RCA,
    ST_SELECT,
    ST_BUS_W,
    ST_HS,
    ST_BLKLEN,
    ST_READ,
    ST_STOP,
    ST_STATUS
  } step_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ISSUE,
    PH_WAIT,
    PH_BLK
  } phase_t;

  // What completes a step.
  typedef enum logic [1:0] {
    RK_NONE,
    RK_RSP,
    RK_BUSY
  } rkind_t;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic [ARG_W-1:0] arg;
    rkind_t           kind;
  } cmd_t;

  localparam logic [1:0] SW_ACC_WRITE   = 2'b11;
  localparam logic [7:0] XREG_BUS_WIDTH = 8'd183;
  localparam logic [7:0] XREG_HS_TIMING = 8'd185;
  localparam logic [7:0] VAL_BUS8       = 8'h02;
  localparam logic [7:0] VAL_HS_ON      = 8'h01;

  function automatic logic [ARG_W-1:0] switch_arg(input logic [7:0] index,
                                                  input logic [7:0] value);
    return {6'b0, SW_ACC_WRITE, index, value, 5'b0, 3'b000};
  endfunction

endpackage

// File: rtl/mmc_cmd_table.sv
module mmc_cmd_table
  import mmc_seq_pkg::*;
#(
  parameter logic [31:0] OCR_ARG   = 32'h40FF_8080,
  parameter logic [31:0] BLOCK_LEN = 32'd512,
  parameter logic [31:0] READ_ADDR = 32'h0000_0000
) (
  input  step_t            step_i,
  input  logic [RCA_W-1:0] rca_i,
  output cmd_t             cmd_o
);

  logic [ARG_W-1:0] rca_arg;

  assign rca_arg = {rca_i, 16'h0000};

  always_comb begin
    cmd_o = '{idx: '0, arg: '0, kind: RK_NONE};
    case (step_i)
      ST_GO_IDLE: cmd_o = '{idx: 6'd0,  arg: '0,        kind: RK_NONE};
      ST_OP_COND: cmd_o = '{idx: 6'd1,  arg: OCR_ARG,   kind: RK_RSP};
      ST_ALL_CID: cmd_o = '{idx: 6'd2,  arg: '0,        kind: RK_RSP};
      ST_SET_RCA: cmd_o = '{idx: 6'd3,  arg: rca_arg,   kind: RK_RSP};
      ST_SELECT:  cmd_o = '{idx: 6'd7,  arg: rca_arg,   kind: RK_BUSY};
      ST_BUS_W:   cmd_o = '{idx: 6'd6,
                            arg: switch_arg(XREG_BUS_WIDTH, VAL_BUS8),
                            kind: RK_BUSY};
      ST_HS:      cmd_o = '{idx: 6'd6,
                            arg: switch_arg(XREG_HS_TIMING, VAL_HS_ON),
                            kind: RK_BUSY};
      ST_BLKLEN:  cmd_o = '{idx: 6'd16, arg: BLOCK_LEN, kind: RK_RSP};
      ST_READ:    cmd_o = '{idx: 6'd18, arg: READ_ADDR, kind: RK_RSP};
      ST_STOP:    cmd_o = '{idx: 6'd12, arg: '0,        kind: RK_BUSY};
      ST_STATUS:  cmd_o = '{idx: 6'd13, arg: rca_arg,   kind: RK_RSP};
      default:    cmd_o = '{idx: '0,    arg: '0,        kind: RK_NONE};
    endcase
  end

endmodule

// File: rtl/mmc_wait_timer.sv
module mmc_wait_timer #(
  parameter int TIMEOUT = 65536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  output logic expired_o
);

  localparam int               CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(TIMEOUT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             at_last;

  always_comb begin
    at_last = (cnt_q == LAST);
    cnt_en  = clr_i | (run_i & ~at_last);
    cnt_d   = clr_i ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired_o = run_i & at_last;

endmodule

// File: rtl/mmc_blk_counter.sv
module mmc_blk_counter #(
  parameter int BLK_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [BLK_W-1:0] val_i,
  input  logic             dec_i,
  output logic             zero_o,
  output logic             last_o
);

  logic [BLK_W-1:0] left_q;
  logic [BLK_W-1:0] left_d;
  logic             left_en;

  always_comb begin
    left_en = load_i | (dec_i & (left_q != '0));
    left_d  = load_i ? val_i : left_q - BLK_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (left_en) begin
      left_q <= left_d;
    end
  end

  assign zero_o = (left_q == '0);
  assign last_o = (left_q == BLK_W'(1));

endmodule

// File: rtl/mmc_init_seq.sv
module mmc_init_seq
  import mmc_seq_pkg::*;
#(
  parameter int          BLK_W       = 16,
  parameter int          TIMEOUT     = 65536,
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] OCR_ARG     = 32'h40FF_8080,
  parameter logic [31:0] BLOCK_LEN   = 32'd512,
  parameter logic [31:0] READ_ADDR   = 32'h0000_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [15:0]      rca_i,
  input  logic [BLK_W-1:0] blk_cnt_i,
  input  logic             rsp_valid_i,
  input  logic             rsp_ready_i,
  input  logic             busy_clr_i,
  input  logic             blk_done_i,
  output logic             cmd_req_o,
  output logic [5:0]       cmd_idx_o,
  output logic [31:0]      cmd_arg_o,
  output logic             clk_fast_o,
  output logic             done_o,
  output logic             err_o
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_int_n;

  generate
    if (SYNC_STAGES < 2) begin : g_rst_one
      logic rst_ff;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_ff <= 1'b0;
        else        rst_ff <= 1'b1;
      end
      assign rst_int_n = rst_ff;
    end else begin : g_rst_chain
      logic [SYNC_STAGES-1:0] rst_pipe;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= '0;
        else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
      end
      assign rst_int_n = rst_pipe[SYNC_STAGES-1];
    end
  endgenerate

  phase_t           phase_q, phase_d;
  step_t            step_q, step_d, step_next;
  logic [RCA_W-1:0] rca_q;
  logic             rca_en;
  logic             done_q, done_d;
  logic             err_q, err_d;
  logic             fast_q, fast_d;
  logic             blk_load;
  logic             blk_zero, blk_last;
  logic             strobe, accept, blk_acc;
  logic             tmr_clr, tmr_run, expired;
  cmd_t             cmd;

  mmc_cmd_table #(
    .OCR_ARG  (OCR_ARG),
    .BLOCK_LEN(BLOCK_LEN),
    .READ_ADDR(READ_ADDR)
  ) u_table (
    .step_i(step_q),
    .rca_i (rca_q),
    .cmd_o (cmd)
  );

  mmc_wait_timer #(
    .TIMEOUT(TIMEOUT)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clr_i    (tmr_clr),
    .run_i    (tmr_run),
    .expired_o(expired)
  );

  mmc_blk_counter #(
    .BLK_W(BLK_W)
  ) u_blocks (
    .clk   (clk),
    .rst_n (rst_int_n),
    .load_i(blk_load),
    .val_i (blk_cnt_i),
    .dec_i (blk_acc),
    .zero_o(blk_zero),
    .last_o(blk_last)
  );

  always_comb begin
    strobe    = (cmd.kind == RK_BUSY) ? busy_clr_i : rsp_valid_i;
    accept    = (phase_q == PH_WAIT) & strobe;
    blk_acc   = (phase_q == PH_BLK) & blk_done_i;
    tmr_run   = (phase_q == PH_WAIT) | (phase_q == PH_BLK);
    tmr_clr   = (phase_q == PH_ISSUE) | accept | blk_acc;
    step_next = step_t'(step_q + 4'd1);
  end

  // Next-state logic
  always_comb begin
    phase_d  = phase_q;
    step_d   = step_q;
    done_d   = done_q;
    err_d    = err_q;
    fast_d   = fast_q;
    rca_en   = 1'b0;
    blk_load = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          done_d = 1'b0;
          fast_d = 1'b0;
          if (rca_i == '0) begin
            err_d = 1'b1;
          end else begin
            err_d    = 1'b0;
            rca_en   = 1'b1;
            blk_load = 1'b1;
            step_d   = ST_GO_IDLE;
            phase_d  = PH_ISSUE;
          end
        end
      end
      PH_ISSUE: begin
        if (cmd.kind == RK_NONE) step_d  = step_next;
        else                     phase_d = PH_WAIT;
      end
      PH_WAIT: begin
        if (accept) begin
          phase_d = PH_ISSUE;
          step_d  = step_next;
          case (step_q)
            ST_OP_COND: if (!rsp_ready_i) step_d = step_q;
            ST_HS:      fast_d = 1'b1;
            ST_READ:    if (!blk_zero) phase_d = PH_BLK;
            ST_STATUS: begin
              phase_d = PH_IDLE;
              step_d  = ST_GO_IDLE;
              done_d  = 1'b1;
            end
            default: ;
          endcase
        end else if (expired) begin
          phase_d = PH_IDLE;
          err_d   = 1'b1;
          fast_d  = 1'b0;
        end
      end
      PH_BLK: begin
        if (blk_acc) begin
          if (blk_last) begin
            phase_d = PH_ISSUE;
            step_d  = ST_STOP;
          end
        end else if (expired) begin
          phase_d = PH_IDLE;
          err_d   = 1'b1;
          fast_d  = 1'b0;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      phase_q <= PH_IDLE;
      step_q  <= ST_GO_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      fast_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      step_q  <= step_d;
      done_q  <= done_d;
      err_q   <= err_d;
      fast_q  <= fast_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rca_q <= '0;
    end else if (rca_en) begin
      rca_q <= rca_i;
    end
  end

  assign cmd_req_o  = (phase_q == PH_ISSUE);
  assign cmd_idx_o  = cmd.idx;
  assign cmd_arg_o  = cmd.arg;
  assign clk_fast_o = fast_q;
  assign done_o     = done_q;
  assign err_o      = err_q;

endmodule

// File: rtl/mmc_init_seq_chk.sv
module mmc_init_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_req_o,
  input logic [5:0]  cmd_idx_o,
  input logic [31:0] cmd_arg_o,
  input logic        clk_fast_o,
  input logic        done_o,
  input logic        err_o,
  input logic        rsp_valid_i,
  input logic        busy_clr_i
);

  // R3
  single_pulse_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req_o && cmd_idx_o != 6'd0) |=> !cmd_req_o);

  // R5
  switch_arg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req_o && cmd_idx_o == 6'd6) |->
      (cmd_arg_o[31:26] == 6'd0 && cmd_arg_o[7:0] == 8'd0));

  // R8
  fast_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_fast_o) |-> $past(busy_clr_i));

  // R9
  done_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(rsp_valid_i));

  // R9
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

  // R10
  quiet_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !cmd_req_o);

endmodule

bind mmc_init_seq mmc_init_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_req_o  (cmd_req_o),
  .cmd_idx_o  (cmd_idx_o),
  .cmd_arg_o  (cmd_arg_o),
  .clk_fast_o (clk_fast_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .rsp_valid_i(rsp_valid_i),
  .busy_clr_i (busy_clr_i)
);

// File: tb/mmc_init_seq_test.sv
`timescale 1ns/1ps
module mmc_init_seq_test;

  localparam int          TO      = 16;
  localparam int          BW      = 4;
  localparam logic [31:0] TB_OCR  = 32'h40FF_8080;
  localparam logic [31:0] TB_BLEN = 32'd512;
  localparam logic [31:0] TB_ADDR = 32'h0000_0800;
  localparam int          GAP     = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic [15:0]   rca_i;
  logic [BW-1:0] blk_cnt_i;
  logic          rsp_valid_i, rsp_ready_i, busy_clr_i, blk_done_i;
  logic          cmd_req_o;
  logic [5:0]    cmd_idx_o;
  logic [31:0]   cmd_arg_o;
  logic          clk_fast_o, done_o, err_o;

  always #2 clk = ~clk;

  mmc_init_seq #(
    .BLK_W(BW), .TIMEOUT(TO), .SYNC_STAGES(2),
    .OCR_ARG(TB_OCR), .BLOCK_LEN(TB_BLEN), .READ_ADDR(TB_ADDR)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rca_i(rca_i),
    .blk_cnt_i(blk_cnt_i), .rsp_valid_i(rsp_valid_i),
    .rsp_ready_i(rsp_ready_i), .busy_clr_i(busy_clr_i),
    .blk_done_i(blk_done_i), .cmd_req_o(cmd_req_o),
    .cmd_idx_o(cmd_idx_o), .cmd_arg_o(cmd_arg_o),
    .clk_fast_o(clk_fast_o), .done_o(done_o), .err_o(err_o)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  int polls_cfg, nblk_cfg, dmode_cfg, hang_cfg, late_cfg;
  int ncmd, op_seen, last_blk;
  logic [5:0]  g_idx  [0:31];
  logic [31:0] g_arg  [0:31];
  logic        g_fast [0:31];
  int          g_req  [0:31];
  int          g_stb  [0:31];

  task automatic check(input bit ok, input string req, input longint act,
                       input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int delay_for(input int n);
    case (dmode_cfg)
      0:       return 1;
      1:       return TO;
      2:       return 1 + (n * 5) % TO;
      default: return 2 + (n % 3);
    endcase
  endfunction

  function automatic logic [31:0] sw_arg(input int index, input int value);
    return (32'd3 << 24) | (32'(index) << 16) | (32'(value) << 8);
  endfunction

  // Expected {index, argument} for position n of the sequence.
  function automatic logic [37:0] exp_cmd(input int n, input int p,
                                          input logic [15:0] r);
    if (n == 0) return {6'd0, 32'd0};
    if (n <= p) return {6'd1, TB_OCR};
    case (n - p)
      1:       return {6'd2, 32'd0};
      2:       return {6'd3, r, 16'h0};
      3:       return {6'd7, r, 16'h0};
      4:       return {6'd6, sw_arg(183, 2)};
      5:       return {6'd6, sw_arg(185, 1)};
      6:       return {6'd16, TB_BLEN};
      7:       return {6'd18, TB_ADDR};
      8:       return {6'd12, 32'd0};
      default: return {6'd13, r, 16'h0};
    endcase
  endfunction

  // Device model: answers each request after a programmed delay.
  initial begin : responder
    int   pend, cnt, dly, bleft, bcnt, cur;
    logic busyk;
    logic [5:0] cidx;
    pend = 0; bleft = 0; bcnt = 0; cur = 0; dly = 0; cnt = 0;
    busyk = 1'b0; cidx = '0;
    rsp_valid_i = 1'b0; rsp_ready_i = 1'b0; busy_clr_i = 1'b0; blk_done_i = 1'b0;
    forever begin
      @(negedge clk);
      rsp_valid_i = 1'b0; rsp_ready_i = 1'b0;
      busy_clr_i  = 1'b0; blk_done_i  = 1'b0;
      if (cmd_req_o) begin
        cur  = ncmd;
        cidx = cmd_idx_o;
        if (cur < 32) begin
          g_idx[cur]  = cmd_idx_o;
          g_arg[cur]  = cmd_arg_o;
          g_fast[cur] = clk_fast_o;
          g_req[cur]  = cyc;
        end
        ncmd++;
        busyk = (cidx == 6'd6) || (cidx == 6'd7) || (cidx == 6'd12);
        if (cidx == 6'd1) op_seen++;
        pend = 0;
        if (cidx != 6'd0 && cur != hang_cfg) begin
          pend = 1; dly = delay_for(cur); cnt = dly;
        end else if (cidx != 6'd0 && late_cfg != 0) begin
          pend = 1; dly = TO + 1; cnt = dly;
        end
      end else if (pend != 0) begin
        cnt--;
        if (dmode_cfg == 3 && cnt == dly - 1 && cnt != 0) begin
          if (busyk) rsp_valid_i = 1'b1;
          else       busy_clr_i  = 1'b1;
        end
        if (cnt == 0) begin
          pend = 0;
          if (busyk) busy_clr_i = 1'b1;
          else begin
            rsp_valid_i = 1'b1;
            rsp_ready_i = (cidx == 6'd1) && (op_seen >= polls_cfg);
          end
          if (cur < 32) g_stb[cur] = cyc;
          if (cidx == 6'd18 && nblk_cfg > 0) begin
            bleft = nblk_cfg; bcnt = GAP;
          end
        end
      end else if (bleft > 0) begin
        bcnt--;
        if (bcnt == 0) begin
          blk_done_i = 1'b1;
          bleft--;
          bcnt = GAP;
          last_blk = cyc;
        end
      end
    end
  end

  task automatic run_case(input int p, input int nb, input int dm,
                          input int hang, input int late);
    int lim, endc, s0, expn, ecnt;
    logic [15:0] r;
    logic [37:0] e;
    @(negedge clk);
    polls_cfg = p; nblk_cfg = nb; dmode_cfg = dm;
    hang_cfg = hang; late_cfg = late;
    ncmd = 0; op_seen = 0; last_blk = -1;
    r = 16'h5A3C + 16'(p * 7 + nb);
    rca_i = r; blk_cnt_i = BW'(nb); start_i = 1'b1;
    s0 = cyc;
    @(negedge clk);
    start_i = 1'b0; rca_i = 16'hFFFF; blk_cnt_i = '1;
    lim = 1;
    while (!(done_o || err_o) && lim < 3000) begin
      @(negedge clk);
      lim++;
      start_i = (dm == 2 && lim == 9);  // R12: start while running
    end
    start_i = 1'b0;
    endc = cyc;
    repeat (40) @(negedge clk);
    expn = (hang >= 0) ? hang + 1 : p + 10;
    check(ncmd == expn, "R2 R10 R12 command count", ncmd, expn);
    ecnt = (ncmd < expn) ? ncmd : expn;
    for (int n = 0; n < ecnt && n < 32; n++) begin
      e = exp_cmd(n, p, r);
      check(g_idx[n] == e[37:32], "R2 index", g_idx[n], e[37:32]);
      check(g_arg[n] == e[31:0], "R4 R5 argument", g_arg[n], e[31:0]);
      check(g_fast[n] == (n >= p + 6), "R8 fast clock at request",
            g_fast[n], (n >= p + 6));
      if (n == 0)
        check(g_req[0] == s0 + 1, "R3 first request", g_req[0], s0 + 1);
      else if (g_idx[n-1] == 6'd0)
        check(g_req[n] == g_req[n-1] + 1, "R3 after reset command",
              g_req[n], g_req[n-1] + 1);
      else if (g_idx[n] == 6'd12 && nb > 0)
        check(g_req[n] == last_blk + 1, "R7 stop after last block",
              g_req[n], last_blk + 1);
      else
        check(g_req[n] == g_stb[n-1] + 1, "R3 R6 R7 request after strobe",
              g_req[n], g_stb[n-1] + 1);
    end
    if (hang < 0) begin
      check(done_o == 1'b1 && err_o == 1'b0, "R9 done sticky", {done_o, err_o}, 2'b10);
      check(endc == g_stb[p+9] + 1, "R9 done timing", endc, g_stb[p+9] + 1);
      check(clk_fast_o == 1'b1, "R8 fast at end", clk_fast_o, 1);
    end else begin
      check(err_o == 1'b1 && done_o == 1'b0, "R10 error flag", {done_o, err_o}, 2'b01);
      check(endc == g_req[hang] + TO + 1, "R10 error timing", endc, g_req[hang] + TO + 1);
      check(clk_fast_o == 1'b0, "R8 fast cleared by error", clk_fast_o, 0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int hang_n;
    rst_n = 1'b0; start_i = 1'b0; rca_i = '0; blk_cnt_i = '0;
    polls_cfg = 1; nblk_cfg = 0; dmode_cfg = 0; hang_cfg = -1; late_cfg = 0;
    ncmd = 0; op_seen = 0; last_blk = -1;
    repeat (3) @(negedge clk);
    // R1
    check({cmd_req_o, done_o, err_o, clk_fast_o} == 4'b0, "R1 reset outputs",
          {cmd_req_o, done_o, err_o, clk_fast_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({cmd_req_o, done_o, err_o, clk_fast_o} == 4'b0, "R1 after release",
          {cmd_req_o, done_o, err_o, clk_fast_o}, 0);

    // R11: zero address rejected
    rca_i = 16'h0000; blk_cnt_i = BW'(1); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(err_o == 1'b1, "R11 error on zero address", err_o, 1);
    repeat (30) @(negedge clk);
    check(ncmd == 0, "R11 no command issued", ncmd, 0);

    // Full runs: polls x block count x delay pattern
    for (int p = 1; p <= 3; p++)
      for (int nb = 0; nb <= 3; nb++)
        for (int dm = 0; dm <= 3; dm++)
          run_case(p, nb, dm, -1, 0);

    // R10: each waiting step left unanswered, alternately answered late
    for (int h = 1; h <= 11; h++) begin
      hang_n = h;
      run_case(2, 2, 2, hang_n, h % 2);
    end

    // Recovery after an error
    run_case(1, 1, 0, -1, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule